// File: doc/BRIEF.md
# OTP programming-entry controller

This block watches the external control pins of a one-time-programmable memory and recognises the fixed pin ordering that moves the device into programming mode. First the pins must reach a defined idle pattern. Then the select pin must fall, which captures the write-strobe and supply-level states. Finally the write strobe must rise. After that the block decodes the mode-select lines, the supply-level flag and the two strobes into commands for the memory array. The possible accesses are byte program, byte read, lock-bit program, lock-bit read and version-byte read.

Leaving programming mode is tracked. If a nonzero protection level is stored when the mode is left, the block refuses every later entry until the system reset. An encoded status output shows how far the entry sequence has progressed. The high-voltage generator and the memory cells sit outside the block. All pins are taken as already synchronous to `clk`.

Top module: `otp_prog_entry`

## Requirements
- R1: After `rst_n` is low, `entry_state` is 0 (idle), all command outputs are 0 and `rd_data` is 0.
- R2: From idle, the state becomes 1 (conditioned) one clock after these levels hold together: `ext_rst`=0, `store_en`=0, `wr_strb_n`=0, `addr_lat`=0, `mode_sel`=2'b01, `supply_lvl`=2'b00, `rd_strb_n`=1 and `entry_sel`=1. If any of these levels except `entry_sel` breaks while the state is 1, the state returns to 0.
- R3: In state 1, a clock with `entry_sel`=0 and all other conditioning levels intact moves the state to 2 (latched). The write-strobe and supply-level states are captured at that point. In state 2, `wr_strb_n`=1 moves the state to 3 (ready).
- R4: In state 2 or 3, any clock with `ext_rst`, `store_en` or `entry_sel` at 1 leaves programming mode. The next state is 0 when `prot_level` is 0.
- R5: Leaving programming mode with `prot_level` nonzero moves the state to 4 (locked out). State 4 ignores all pins and holds until `rst_n` is low.
- R6: In state 3 with `mode_sel`=2'b11 and `supply_lvl`=2'b10 (programming level), a falling edge of `wr_strb_n` gives `arr_we`=1 for exactly one clock, starting the cycle after the edge is sampled. During that cycle, `arr_addr` and `arr_wdata` carry the target address and data.
- R7: In state 3 with `mode_sel`=2'b11, `supply_lvl`=2'b01 (read level) and `rd_strb_n`=0, `arr_re`=1 and `rd_data` equals `arr_rdata` in the same cycle.
- R8: With `mode_sel`=2'b10, a write pulse under R6's conditions drives `lock_we` instead of `arr_we`, and the lock bits travel on data bits 1:0. A read under R7's conditions drives `lock_re` and returns the lock bits in `rd_data[1:0]`, with the upper bits 0.
- R9: In state 3 with `mode_sel`=2'b01, read level and `rd_strb_n`=0, `ver_re`=1 and `rd_data` equals `ver_rdata` for the byte address on `arr_addr`.
- R10: In state 3, `addr_lat`=1 loads `addr_in` into the high address byte at the clock edge. `arr_addr` is {high byte, current `addr_in`}.
- R11: `mode_sel`=2'b00 or `supply_lvl` at 2'b00 or 2'b11 gives no command and `rd_data`=0. A write-strobe fall at read level gives no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, the only way out of lockout |
| ext_rst | input | 1 | External reset pin level |
| store_en | input | 1 | Program-store-enable pin level |
| wr_strb_n | input | 1 | Write strobe, active low once ready |
| rd_strb_n | input | 1 | Read strobe, active low |
| addr_lat | input | 1 | Address-latch strobe, 1 loads the high address byte |
| entry_sel | input | 1 | Programming select pin |
| mode_sel | input | 2 | Access-mode select lines |
| supply_lvl | input | 2 | Supply level: 00 low, 01 read, 10 program, 11 invalid |
| addr_in | input | 8 | Address port |
| data_in | input | 8 | Data port, write direction |
| prot_level | input | 2 | Stored protection level |
| arr_rdata | input | 8 | Byte read from the array |
| lock_rdata | input | 2 | Current lock bits |
| ver_rdata | input | 8 | Version byte at the addressed location |
| arr_addr | output | 16 | Array address |
| arr_wdata | output | 8 | Write data for the array or the lock bits |
| arr_we | output | 1 | One-cycle array byte program pulse |
| arr_re | output | 1 | Array byte read |
| lock_we | output | 1 | One-cycle lock-bit program pulse |
| lock_re | output | 1 | Lock-bit read |
| ver_re | output | 1 | Version-byte read |
| rd_data | output | 8 | Read data toward the data port |
| entry_state | output | 3 | 0 idle, 1 conditioned, 2 latched, 3 ready, 4 locked out |

## Verification
The bench breaks a conditioning level before the select pin falls, to confirm that the sequence restarts. A design that failed to restart would enter programming mode out of order. It holds the write strobe low for several cycles after its fall. A level-triggered design would emit a stretched `arr_we` there instead of a single pulse. It leaves the mode with a nonzero protection level and then replays the full entry sequence. A design with a non-sticky lockout would walk back into the ready state. It also applies undefined mode codes, a low supply level and a write at read level. A loosely decoded design would leak array commands or stale read data in those cases.

// File: rtl/otp_prog_entry.sv
module otp_prog_entry #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LOCK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_rst,
  input  logic                  store_en,
  input  logic                  wr_strb_n,
  input  logic                  rd_strb_n,
  input  logic                  addr_lat,
  input  logic                  entry_sel,
  input  logic [1:0]            mode_sel,
  input  logic [1:0]            supply_lvl,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [DATA_W-1:0]     data_in,
  input  logic [1:0]            prot_level,
  input  logic [DATA_W-1:0]     arr_rdata,
  input  logic [LOCK_W-1:0]     lock_rdata,
  input  logic [DATA_W-1:0]     ver_rdata,
  output logic [2*ADDR_W-1:0]   arr_addr,
  output logic [DATA_W-1:0]     arr_wdata,
  output logic                  arr_we,
  output logic                  arr_re,
  output logic                  lock_we,
  output logic                  lock_re,
  output logic                  ver_re,
  output logic [DATA_W-1:0]     rd_data,
  output logic [2:0]            entry_state
);

  localparam int PAD_W = DATA_W - LOCK_W;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_COND = 3'd1,
    S_LAT  = 3'd2,
    S_RDY  = 3'd3,
    S_LOCK = 3'd4
  } st_t;

  st_t state, state_nx;
  logic wr_q;
  logic [ADDR_W-1:0] hi_q;
  logic arr_we_q, lock_we_q;

  wire base_ok = !ext_rst && !store_en && !wr_strb_n && !addr_lat &&
                 (mode_sel == 2'b01) && (supply_lvl == 2'b00) && rd_strb_n;
  wire leave   = ext_rst || store_en || entry_sel;
  wire rdy     = (state == S_RDY);
  wire v_rd    = (supply_lvl == 2'b01);
  wire v_pg    = (supply_lvl == 2'b10);
  wire wr_fall = wr_q && !wr_strb_n;
  wire rd_act  = rdy && !rd_strb_n && v_rd;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: if (base_ok && entry_sel) state_nx = S_COND;
      S_COND: begin
        if (!base_ok)        state_nx = S_IDLE;
        else if (!entry_sel) state_nx = S_LAT;
      end
      S_LAT, S_RDY: begin
        if (leave)
          state_nx = (prot_level != 2'b00) ? S_LOCK : S_IDLE;
        else if (state == S_LAT && wr_strb_n)
          state_nx = S_RDY;
      end
      S_LOCK:  state_nx = S_LOCK;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wr_q      <= 1'b0;
      hi_q      <= '0;
      arr_we_q  <= 1'b0;
      lock_we_q <= 1'b0;
    end else begin
      state     <= state_nx;
      wr_q      <= wr_strb_n;
      if (rdy && addr_lat) hi_q <= addr_in;
      arr_we_q  <= rdy && wr_fall && v_pg && (mode_sel == 2'b11);
      lock_we_q <= rdy && wr_fall && v_pg && (mode_sel == 2'b10);
    end
  end

  assign arr_re  = rd_act && (mode_sel == 2'b11);
  assign lock_re = rd_act && (mode_sel == 2'b10);
  assign ver_re  = rd_act && (mode_sel == 2'b01);

  assign rd_data = arr_re  ? arr_rdata :
                   lock_re ? {{PAD_W{1'b0}}, lock_rdata} :
                   ver_re  ? ver_rdata : '0;

  assign arr_addr    = {hi_q, addr_in};
  assign arr_wdata   = data_in;
  assign arr_we      = arr_we_q;
  assign lock_we     = lock_we_q;
  assign entry_state = state;

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  // R8
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_we, lock_we}));

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK) |=> (state == S_LOCK));

  // R4
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_LAT || state == S_RDY) && store_en) |=>
      (state == S_IDLE || state == S_LOCK));

  // R3
  ready_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_RDY) |-> ($past(state) == S_LAT));

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 || supply_lvl == 2'b00) |-> (rd_data == '0));

endmodule

// File: tb/otp_prog_entry_tb.sv
`timescale 1ns/1ps
module otp_prog_entry_tb_top;
  logic clk = 0, rst_n = 0;
  logic ext_rst = 1, store_en = 1, wr_strb_n = 1, rd_strb_n = 1, addr_lat = 0, entry_sel = 1;
  logic [1:0] mode_sel = 2'b00, supply_lvl = 2'b00, prot_level = 2'b00;
  logic [7:0] addr_in = 0, data_in = 0;
  logic [7:0] arr_rdata, ver_rdata;
  logic [1:0] lock_rdata;
  logic [15:0] arr_addr;
  logic [7:0] arr_wdata, rd_data;
  logic arr_we, arr_re, lock_we, lock_re, ver_re;
  logic [2:0] entry_state;

  always #4 clk = ~clk;

  assign arr_rdata  = arr_addr[7:0] ^ 8'h5A;
  assign ver_rdata  = arr_addr[7:0] + 8'h30;
  assign lock_rdata = 2'b10;

  otp_prog_entry dut_i (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .store_en(store_en),
    .wr_strb_n(wr_strb_n), .rd_strb_n(rd_strb_n), .addr_lat(addr_lat),
    .entry_sel(entry_sel), .mode_sel(mode_sel), .supply_lvl(supply_lvl),
    .addr_in(addr_in), .data_in(data_in), .prot_level(prot_level),
    .arr_rdata(arr_rdata), .lock_rdata(lock_rdata), .ver_rdata(ver_rdata),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_re(arr_re),
    .lock_we(lock_we), .lock_re(lock_re), .ver_re(ver_re), .rd_data(rd_data),
    .entry_state(entry_state));

  typedef struct { string req; int fld; logic [31:0] val; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int fld);
    case (fld)
      0: return {29'd0, entry_state};
      1: return {31'd0, arr_we};
      2: return {31'd0, lock_we};
      3: return {31'd0, arr_re};
      4: return {31'd0, lock_re};
      5: return {31'd0, ver_re};
      6: return {24'd0, rd_data};
      7: return {16'd0, arr_addr};
      default: return {24'd0, arr_wdata};
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = observe(it.fld);
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s field=%0d actual=%h expected=%h", it.req, it.fld, act, it.val);
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); @(negedge clk); #1; endtask
  task automatic expect_v(string req, int fld, logic [31:0] v);
    sb.push_back('{req, fld, v});
  endtask

  task automatic condition_pins();
    ext_rst = 0; store_en = 0; wr_strb_n = 0; addr_lat = 0;
    mode_sel = 2'b01; supply_lvl = 2'b00; rd_strb_n = 1; entry_sel = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    settle();
    tick();
    expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 6, 0);
    settle();
    rst_n = 1;
    condition_pins();
    tick(); expect_v("R2", 0, 1); settle();
    addr_lat = 1;
    tick(); expect_v("R2", 0, 0); settle();
    addr_lat = 0;
    tick(); expect_v("R2", 0, 1); settle();
    entry_sel = 0;
    tick(); expect_v("R3", 0, 2); settle();
    wr_strb_n = 1;
    tick(); expect_v("R3", 0, 3); settle();
    // R10 high byte then low byte
    supply_lvl = 2'b10; mode_sel = 2'b11; addr_lat = 1; addr_in = 8'h12;
    tick(); settle();
    addr_lat = 0; addr_in = 8'h34; data_in = 8'hA5;
    tick(); expect_v("R10", 7, 16'h1234); settle();
    wr_strb_n = 0;
    tick(); expect_v("R6", 1, 1); expect_v("R6", 7, 16'h1234); expect_v("R6", 8, 8'hA5); settle();
    tick(); expect_v("R6", 1, 0); settle();
    wr_strb_n = 1;
    tick(); settle();
    supply_lvl = 2'b01; rd_strb_n = 0;
    tick(); expect_v("R7", 3, 1); expect_v("R7", 6, 8'h34 ^ 8'h5A); settle();
    mode_sel = 2'b10;
    tick(); expect_v("R8", 4, 1); expect_v("R8", 6, 8'h02); expect_v("R8", 3, 0); settle();
    rd_strb_n = 1; supply_lvl = 2'b10; data_in = 8'h03;
    tick(); settle();
    wr_strb_n = 0;
    tick(); expect_v("R8", 2, 1); expect_v("R8", 1, 0); settle();
    wr_strb_n = 1;
    tick(); settle();
    mode_sel = 2'b01; supply_lvl = 2'b01; rd_strb_n = 0;
    tick(); expect_v("R9", 5, 1); expect_v("R9", 6, 8'h34 + 8'h30); settle();
    mode_sel = 2'b00;
    tick(); expect_v("R11", 6, 0); expect_v("R11", 3, 0); settle();
    mode_sel = 2'b11; supply_lvl = 2'b00;
    tick(); expect_v("R11", 6, 0); expect_v("R11", 3, 0); settle();
    supply_lvl = 2'b11;
    tick(); expect_v("R11", 6, 0); settle();
    rd_strb_n = 1; supply_lvl = 2'b01;
    tick(); settle();
    wr_strb_n = 0;
    tick(); expect_v("R11", 1, 0); settle();
    wr_strb_n = 1;
    tick(); settle();
    store_en = 1;
    tick(); expect_v("R4", 0, 0); settle();
    condition_pins();
    tick(); expect_v("R2", 0, 1); settle();
    entry_sel = 0;
    tick(); expect_v("R3", 0, 2); settle();
    prot_level = 2'b01; entry_sel = 1;
    tick(); expect_v("R5", 0, 4); settle();
    condition_pins();
    tick(); expect_v("R5", 0, 4); settle();
    entry_sel = 0;
    tick(); expect_v("R5", 0, 4); settle();
    wr_strb_n = 1;
    tick(); expect_v("R5", 0, 4); settle();
    rst_n = 0;
    tick(); expect_v("R1", 0, 0); settle();
    rst_n = 1;
    tick(); settle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule